// File: doc/BRIEF.md
# Packed Decimal Integer Converter

The block converts a signed two's-complement binary integer to and from a ten-byte packed-decimal word. The low nine bytes of the decimal word carry eighteen decimal digits, two per byte. The top byte carries only the sign. A mode input picks the direction when a conversion is started. In load mode the decimal word is turned into a binary integer. In store mode a binary integer is turned into a decimal word.

Work is iterative and handles one digit pair per cycle, with a single `start` pulse and a `busy`/`done` handshake. The controller has four states. `S_IDLE` moves to `S_SETUP` when `start` is seen. `S_SETUP` always moves to `S_STEP`. `S_STEP` repeats once for each digit pair and moves to `S_FINISH` on the last pair. `S_FINISH` always returns to `S_IDLE`. The setup state takes the sign and the magnitude from the latched operand and clears the result being built. Each step state folds in one digit pair (load) or peels one off (store). The finish state raises `done` for one cycle. Results stay on the output buses until a later conversion replaces them.

Top module: `bcd_pack_conv`

## Requirements
- R1: After reset `busy`, `done` and `invalid` are 0, and `bin_out` and `bcd_out` are all zero.
- R2: A `start` seen high in the idle state raises `busy` in the next cycle. `busy` then stays high for exactly 10 cycles (one setup cycle plus 9 steps). `done` is high for exactly one cycle, in the 11th cycle after the start edge. `busy` and `done` are never high together.
- R3: `start` is ignored while `busy` or `done` is high. The running conversion completes with the operands latched at its own start, and no new conversion follows.
- R4: Load (`to_bin`=1): bits [8k+7:8k] for k=0..8 form byte k. Its high nibble is the tens digit and its low nibble the units digit. Byte 8 is the most significant. The result is built from byte 8 down to byte 0 as acc = acc*100 + hi*10 + lo, modulo 2^64.
- R5: Load: only bit 79 is the sign. When it is 1 the result is the two's-complement negation of the accumulated magnitude. Bits 78:72 have no effect.
- R6: Load: `invalid` is 1 at `done` exactly when some nibble in bits 71:0 is above 9. The result still follows the R4 arithmetic using the raw nibble values.
- R7: Store (`to_bin`=0): bits 79:72 are 8'h80 when the input is negative and 8'h00 otherwise. The magnitude (including 2^63 for the most negative input) is what gets converted.
- R8: Store: nibble j of bits 71:0 (bits [4j+3:4j]) holds decimal digit j of the magnitude, with digit 0 the units digit. Digit pairs above the highest nonzero one are zero.
- R9: Store: `invalid` is 1 at `done` exactly when the magnitude is above 999999999999999999. The digit field then holds the low 18 decimal digits of the magnitude.
- R10: Outputs change only during a conversion. A load leaves `bcd_out` unchanged, and a store leaves `bin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion (taken only when idle) |
| to_bin | input | 1 | Mode: 1 = decimal to binary, 0 = binary to decimal |
| bin_in | input | 64 | Signed binary operand for store |
| bcd_in | input | 80 | Packed-decimal operand for load |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| bin_out | output | 64 | Binary result of the last load |
| bcd_out | output | 80 | Packed-decimal result of the last store |
| invalid | output | 1 | Bad digit (load) or magnitude out of range (store) |

## Verification
Loads are tried with a full eighteen-digit word, with junk in the sign byte both with and without bit 79, and with a nibble of ten. These separate correct digit weighting, testing of the sign bit alone, and flagging a bad digit while keeping the raw arithmetic. Stores are tried with zero, small positives and negatives, exactly 10^18−1 and 10^18, and the most negative integer. These separate zero-filling of the upper pairs, the sign byte, the range boundary, and wrap in the magnitude. Restarts during `busy` and during `done` show that the latched operands are kept, and random operands in both modes are followed clock by clock against a behavioural model.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_STEP,
        S_FINISH
    } conv_state_t;

    // Largest magnitude that fits in the given number of decimal digits.
    function automatic logic [63:0] dec_ceiling(input int digits);
        logic [63:0] p;
        p = 64'd1;
        for (int i = 0; i < digits; i++) begin
            p = p * 64'd10;
        end
        return p - 64'd1;
    endfunction

endpackage

// File: rtl/bcdc_pair_dec.sv
module bcdc_pair_dec (
    input  logic [7:0] pair,
    output logic [7:0] value,
    output logic       bad
);
    logic [3:0] tens;
    logic [3:0] units;

    assign tens  = pair[7:4];
    assign units = pair[3:0];
    // tens*10 = tens*8 + tens*2; maximum 15*10+15 = 165 fits in 8 bits
    assign value = {1'b0, tens, 3'b000} + {3'b000, tens, 1'b0} + {4'b0000, units};
    assign bad   = (tens > 4'd9) || (units > 4'd9);
endmodule

// File: rtl/bcdc_pair_enc.sv
module bcdc_pair_enc (
    input  logic [6:0] value,
    output logic [7:0] pair
);
    logic [6:0] tens;
    logic [6:0] units;

    assign tens  = value / 7'd10;
    assign units = value - (tens * 7'd10);
    assign pair  = {tens[3:0], units[3:0]};
endmodule

// File: rtl/bcd_pack_conv.sv
module bcd_pack_conv #(
    parameter  int DIGIT_PAIRS = 9,
    parameter  int WORD_W      = 64,
    localparam int BUS_W       = (DIGIT_PAIRS + 1) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_bin,
    input  logic [WORD_W-1:0] bin_in,
    input  logic [BUS_W-1:0]  bcd_in,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] bin_out,
    output logic [BUS_W-1:0]  bcd_out,
    output logic              invalid
);
    import bcdc_pkg::*;

    localparam int CNT_W    = (DIGIT_PAIRS > 1) ? $clog2(DIGIT_PAIRS) : 1;
    localparam int MAG_BITS = DIGIT_PAIRS * 8;
    localparam logic [WORD_W-1:0] MAG_LIMIT = WORD_W'(dec_ceiling(2 * DIGIT_PAIRS));

    conv_state_t state_q, state_d;

    logic [CNT_W-1:0]    step_q;
    logic                dir_q;
    logic                neg_q;
    logic                bad_q;
    logic                src_sign_q;
    logic [MAG_BITS-1:0] src_mag_q;
    logic [WORD_W-1:0]   src_bin_q;
    logic [WORD_W-1:0]   acc_q;
    logic [WORD_W-1:0]   mag_q;
    logic [WORD_W-1:0]   bin_q;
    logic [BUS_W-1:0]    bcd_q;

    logic                last_step;
    int                  load_idx;
    int                  store_idx;
    logic [7:0]          load_pair;
    logic [7:0]          load_val;
    logic                load_bad;
    logic [WORD_W-1:0]   acc_next;
    logic                in_neg;
    logic [WORD_W-1:0]   in_abs;
    logic [6:0]          store_rem;
    logic [7:0]          store_pair;

    assign last_step = (step_q == CNT_W'(DIGIT_PAIRS - 1));
    assign load_idx  = DIGIT_PAIRS - 1 - int'(step_q);
    assign store_idx = int'(step_q);
    assign load_pair = src_mag_q[load_idx*8 +: 8];
    assign acc_next  = (acc_q * WORD_W'(100)) + WORD_W'(load_val);
    assign in_neg    = src_bin_q[WORD_W-1];
    assign in_abs    = in_neg ? (~src_bin_q + WORD_W'(1)) : src_bin_q;
    assign store_rem = 7'(mag_q % WORD_W'(100));

    bcdc_pair_dec u_dec (
        .pair  (load_pair),
        .value (load_val),
        .bad   (load_bad)
    );

    bcdc_pair_enc u_enc (
        .value (store_rem),
        .pair  (store_pair)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SETUP;
            S_SETUP:  state_d = S_STEP;
            S_STEP:   if (last_step) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers, advanced per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q     <= '0;
            dir_q      <= 1'b0;
            neg_q      <= 1'b0;
            bad_q      <= 1'b0;
            src_sign_q <= 1'b0;
            src_mag_q  <= '0;
            src_bin_q  <= '0;
            acc_q      <= '0;
            mag_q      <= '0;
            bin_q      <= '0;
            bcd_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        dir_q      <= to_bin;
                        src_bin_q  <= bin_in;
                        src_sign_q <= bcd_in[BUS_W-1];
                        src_mag_q  <= bcd_in[MAG_BITS-1:0];
                    end
                end
                S_SETUP: begin
                    step_q <= '0;
                    if (dir_q) begin
                        acc_q <= '0;
                        bad_q <= 1'b0;
                        neg_q <= src_sign_q;
                    end else begin
                        neg_q <= in_neg;
                        mag_q <= in_abs;
                        bad_q <= (in_abs > MAG_LIMIT);
                        bcd_q <= {(in_neg ? 8'h80 : 8'h00), {MAG_BITS{1'b0}}};
                    end
                end
                S_STEP: begin
                    step_q <= step_q + CNT_W'(1);
                    if (dir_q) begin
                        acc_q <= acc_next;
                        bad_q <= bad_q | load_bad;
                        if (last_step) begin
                            bin_q <= neg_q ? (~acc_next + WORD_W'(1)) : acc_next;
                        end
                    end else begin
                        if (mag_q != '0) begin
                            bcd_q[store_idx*8 +: 8] <= store_pair;
                        end
                        mag_q <= mag_q / WORD_W'(100);
                    end
                end
                S_FINISH: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q == S_SETUP) || (state_q == S_STEP);
        done    = (state_q == S_FINISH);
        bin_out = bin_q;
        bcd_out = bcd_q;
        invalid = bad_q;
    end

endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker #(
    parameter  int DIGIT_PAIRS = 9,
    parameter  int WORD_W      = 64,
    localparam int BUS_W       = (DIGIT_PAIRS + 1) * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              to_bin,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] bin_out,
    input logic [BUS_W-1:0]  bcd_out,
    input logic              invalid
);
    logic [7:0] busy_cnt;
    logic       mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            mode_q   <= 1'b0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
            if (!busy && !done && start) mode_q <= to_bin;
        end
    end

    function automatic logic digits_ok(input logic [BUS_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < 2 * DIGIT_PAIRS; j++) begin
            if (w[j*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 8'(DIGIT_PAIRS + 1)));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(bin_out) && $stable(bcd_out) && $stable(invalid)));

    p_sign_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> (bcd_out[BUS_W-1 -: 8] == 8'h00 || bcd_out[BUS_W-1 -: 8] == 8'h80));

    p_digits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> digits_ok(bcd_out));

endmodule

bind bcd_pack_conv bcdc_checker #(
    .DIGIT_PAIRS (DIGIT_PAIRS),
    .WORD_W      (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .to_bin  (to_bin),
    .busy    (busy),
    .done    (done),
    .bin_out (bin_out),
    .bcd_out (bcd_out),
    .invalid (invalid)
);

// File: tb/bcd_pack_conv_test.sv
`timescale 1ns/1ps
module bcd_pack_conv_test;

    localparam int LAT = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        to_bin = 1'b0;
    logic [63:0] bin_in = '0;
    logic [79:0] bcd_in = '0;
    logic        busy, done, invalid;
    logic [63:0] bin_out;
    logic [79:0] bcd_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bcd_pack_conv uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .to_bin  (to_bin),
        .bin_in  (bin_in),
        .bcd_in  (bcd_in),
        .busy    (busy),
        .done    (done),
        .bin_out (bin_out),
        .bcd_out (bcd_out),
        .invalid (invalid)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference functions
    function automatic void ref_load(input logic [79:0] w, output logic [63:0] r, output bit flag);
        longint unsigned acc = 0;
        flag = 0;
        for (int i = 8; i >= 0; i--) begin
            int hi = int'(w[i*8+4 +: 4]);
            int lo = int'(w[i*8 +: 4]);
            if (hi > 9 || lo > 9) flag = 1;
            acc = acc * 100 + longint'(hi * 10 + lo);
        end
        if (w[79]) acc = -acc;
        r = acc;
    endfunction

    function automatic void ref_store(input logic [63:0] v, output logic [79:0] r, output bit flag);
        longint unsigned mag;
        longint unsigned pw = 1;
        r = '0;
        mag = v[63] ? (~v + 64'd1) : v;
        flag = (mag > 64'd999999999999999999);
        r[79:72] = v[63] ? 8'h80 : 8'h00;
        for (int j = 0; j < 18; j++) begin
            r[j*4 +: 4] = 4'((mag / pw) % 10);
            pw = pw * 10;
        end
    endfunction

    // Cycle model
    int          k = 0;
    logic [63:0] m_bin = '0;
    logic [79:0] m_bcd = '0;
    logic        m_inv = 0;
    bit          m_dir = 0;
    logic [63:0] p_bin;
    logic [79:0] p_bcd;
    bit          p_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; m_bin = '0; m_bcd = '0; m_inv = 0;
        end else if (k == 0) begin
            if (start) begin
                k = 1;
                m_dir = to_bin;
                if (to_bin) ref_load(bcd_in, p_bin, p_bad);
                else        ref_store(bin_in, p_bcd, p_bad);
            end
        end else if (k < LAT) begin
            k++;
            if (k == LAT) begin
                m_inv = p_bad;
                if (m_dir) m_bin = p_bin;
                else       m_bcd = p_bcd;
            end
        end else begin
            k = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (k >= 1 && k < LAT), "R2 busy", 80'(busy), 80'(k >= 1 && k < LAT));
            chk(done == (k == LAT), "R2 done", 80'(done), 80'(k == LAT));
            if (k == 0 || k == LAT) begin
                chk(bin_out == m_bin, "R10 bin_out", 80'(bin_out), 80'(m_bin));
                chk(bcd_out == m_bcd, "R10 bcd_out", bcd_out, m_bcd);
                chk(invalid == m_inv, "R10 invalid", 80'(invalid), 80'(m_inv));
            end
        end
    end

    task automatic run_op(input bit mode, input logic [63:0] b, input logic [79:0] d, output int lat);
        @(negedge clk);
        start = 1; to_bin = mode; bin_in = b; bcd_in = d;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        logic [63:0] eb;
        logic [79:0] ed;
        bit ef;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !invalid, "R1 flags", 80'({busy, done, invalid}), 80'(0));
        chk(bin_out == '0 && bcd_out == '0, "R1 data", bcd_out, 80'(0));
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4: full eighteen-digit load
        run_op(1, 64'd0, 80'h00_123456789012345678, lat);
        chk(lat == LAT, "R2 latency", 80'(lat), 80'(LAT));
        chk(bin_out == 64'd123456789012345678, "R4 load", 80'(bin_out), 80'(64'd123456789012345678));
        chk(invalid == 0, "R6 clean load", 80'(invalid), 80'(0));

        // R5: junk in sign byte without bit 79, then with it
        run_op(1, 64'd0, 80'h7F_000000000000000042, lat);
        chk(bin_out == 64'd42, "R5 junk sign", 80'(bin_out), 80'(42));
        run_op(1, 64'd0, 80'h81_000000000000000042, lat);
        chk(bin_out == -64'sd42, "R5 negative", 80'(bin_out), 80'(-64'sd42));

        // R6: bad nibble flagged, raw arithmetic kept (1*10+10 = 20)
        run_op(1, 64'd0, 80'h00_00000000000000001A, lat);
        chk(invalid == 1, "R6 flag", 80'(invalid), 80'(1));
        chk(bin_out == 64'd20, "R6 value", 80'(bin_out), 80'(20));

        // R7/R8: stores
        run_op(0, -64'sd5, 80'h0, lat);
        chk(bcd_out == 80'h80_000000000000000005, "R7 negative", bcd_out, 80'h80_000000000000000005);
        chk(invalid == 0, "R9 in range", 80'(invalid), 80'(0));
        run_op(0, 64'd1234, 80'h0, lat);
        chk(bcd_out == 80'h00_000000000000001234, "R8 zero fill", bcd_out, 80'h00_000000000000001234);
        run_op(0, 64'd0, 80'h0, lat);
        chk(bcd_out == 80'h0, "R8 zero", bcd_out, 80'h0);

        // R10: a load leaves bcd_out alone
        run_op(0, 64'd987654, 80'h0, lat);
        run_op(1, 64'd0, 80'h00_000000000000000777, lat);
        chk(bcd_out == 80'h00_000000000000987654, "R10 store held", bcd_out, 80'h00_000000000000987654);
        chk(bin_out == 64'd777, "R4 small load", 80'(bin_out), 80'(777));
        run_op(0, 64'd55, 80'h0, lat);
        chk(bin_out == 64'd777, "R10 load held", 80'(bin_out), 80'(777));

        // R9: range boundary and most negative value
        run_op(0, 64'd999999999999999999, 80'h0, lat);
        chk(bcd_out == 80'h00_999999999999999999 && invalid == 0, "R9 max", bcd_out, 80'h00_999999999999999999);
        run_op(0, 64'd1000000000000000000, 80'h0, lat);
        chk(invalid == 1, "R9 over", 80'(invalid), 80'(1));
        chk(bcd_out == 80'h0, "R9 low digits", bcd_out, 80'h0);
        run_op(0, 64'h8000000000000000, 80'h0, lat);
        chk(bcd_out == 80'h80_223372036854775808, "R7 min int", bcd_out, 80'h80_223372036854775808);
        chk(invalid == 1, "R9 min int", 80'(invalid), 80'(1));

        // R3: restart attempts while busy and while done
        @(negedge clk);
        start = 1; to_bin = 0; bin_in = 64'd31; bcd_in = '0;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        start = 1; to_bin = 1; bin_in = 64'd99; bcd_in = 80'h00_000000000000000011;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        chk(bcd_out == 80'h00_000000000000000031, "R3 busy restart", bcd_out, 80'h00_000000000000000031);
        start = 1; to_bin = 0; bin_in = 64'd77;
        @(negedge clk);
        start = 0;
        chk(busy == 0, "R3 done restart", 80'(busy), 80'(0));
        @(negedge clk);
        chk(busy == 0 && bcd_out == 80'h00_000000000000000031, "R3 no run", bcd_out, 80'h00_000000000000000031);

        // Random operands in both modes
        for (int n = 0; n < 40; n++) begin
            bit mode;
            logic [63:0] rb;
            logic [79:0] rd;
            mode = n[0];
            rb = {$urandom, $urandom};
            if (n % 4 == 2) rb = rb % 64'd1000000000000000000;
            rd = {$urandom, $urandom, $urandom};
            if (n % 3 == 0) begin
                for (int j = 0; j < 18; j++) rd[j*4 +: 4] = 4'($urandom % 10);
            end
            run_op(mode, rb, rd, lat);
            if (mode) begin
                ref_load(rd, eb, ef);
                chk(bin_out == eb && invalid == ef, "R4 random load", 80'(bin_out), 80'(eb));
            end else begin
                ref_store(rb, ed, ef);
                chk(bcd_out == ed && invalid == ef, "R8 random store", bcd_out, ed);
            end
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule